// File: doc/BRIEF.md
# Real-Time Clock Periodic Timebase and Interrupt Flags

This block is the timebase and interrupt-status slice of a PC-style real-time clock. A one-cycle strobe `ref_en`, pulsing at the 32.768 kHz reference rate in the system clock domain, advances a prescaler. A 4-bit rate code chooses a periodic tick from that prescaler. The tick sets a periodic flag and can toggle a square-wave pin. Near each prescaler wrap, which marks the once-per-second update, the block raises an update-in-progress status bit for a fixed window.

Alarm-match and update-finished events come from the calendar logic as single-cycle pulses, and each one sets its own flag. Three enable bits gate the flags into one summary flag, and that summary flag drives the active-high interrupt pin. Software reaches four byte-wide registers through a plain select/strobe port. Reading the flag register clears it. The clock-set inhibit bit of the control register is driven out as `set_inhibit` so the calendar can freeze.

Register indices on `reg_sel`: 0 is frequency select, 1 is control, 2 is flags, 3 is validity. `reg_rdata` is combinational from `reg_sel`. Writes and the read-clear take effect at the clock edge where `reg_wr` or `reg_rd` is high. The register port has no back-pressure: every strobe completes in its own cycle.

Top module: `rtc_tick_irq`

## Requirements
- R1: The rate code is bits 3:0 of the frequency register. Code 0 produces no tick. Code n (1..15) produces a tick every 2^(n-1) strobes of `ref_en` while the divider runs, which is 65536>>n Hz for a 32.768 kHz reference. The tick falls on the strobe where the low n-1 prescaler bits are all ones. Each tick sets the periodic flag.
- R2: Bits 6:4 of the frequency register are divider control. 3'b010 runs the prescaler. 3'b110 and 3'b111 clear the prescaler and the update window. Every other value freezes both. No tick and no update occur unless the value is 3'b010.
- R3: The control register (index 1) reads back all 8 written bits and resets to 8'h02. Bit 7 is the clock-set inhibit and drives `set_inhibit`. Bits 6, 5 and 4 enable the periodic, alarm and update flags. Bit 3 enables the square wave.
- R4: The flag register (index 2) reads {summary, periodic, alarm, update, 4'b0}. The summary bit is high when any flag is set together with its enable. Writes to index 2 are ignored.
- R5: A read strobe on index 2 clears all flags at that edge. A flag whose event arrives in the same cycle survives the clear.
- R6: `irq` equals the summary bit at all times.
- R7: `sqw_out` toggles on each tick while control bit 3 is set and the rate code is nonzero. Otherwise it is low from the next edge on.
- R8: Bit 7 of the frequency register reads update-in-progress. It is high while the divider runs and either the prescaler is at or above 2^PRE_W − UIP_LEAD, or fewer than UPD_LEN strobes have passed since the prescaler wrapped. It reads 0 while clock-set inhibit is high.
- R9: `alarm_hit` always sets the alarm flag. `upd_done` sets the update flag only while clock-set inhibit is low.
- R10: The validity register (index 3) always reads 8'h80. Writes to it are ignored.
- R11: The frequency register resets to 8'h26, which is run mode with rate code 6. Bits 6:0 are writable, and bit 7 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle strobe at the reference rate |
| alarm_hit | input | 1 | Alarm-match pulse from calendar |
| upd_done | input | 1 | Update-finished pulse from calendar |
| reg_sel | input | 2 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flags on index 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of selected register |
| irq | output | 1 | Interrupt request, active high |
| sqw_out | output | 1 | Square-wave output |
| set_inhibit | output | 1 | Clock-set inhibit to calendar |

## Verification
The hardest states to reach are the update-in-progress window and a flag read that lands on the same edge as a tick or event pulse. The window needs a full uninterrupted prescaler period with clock-set inhibit low. The bench therefore shrinks the prescaler, then holds run mode and clears the inhibit for an opening directed stretch that crosses several wraps. After that it switches to random register traffic. Frequent flag reads during that traffic collide with random alarm and update pulses and with fast ticks. A cycle-level reference model predicts every output on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    IDX_FREQ  = 2'd0,
    IDX_CTRL  = 2'd1,
    IDX_FLAG  = 2'd2,
    IDX_VALID = 2'd3
  } reg_idx_e;

  localparam int CB_SET  = 7;
  localparam int CB_PIE  = 6;
  localparam int CB_AIE  = 5;
  localparam int CB_UIE  = 4;
  localparam int CB_SQWE = 3;

  localparam logic [2:0] DV_RUN = 3'b010;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } flags_t;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int PRE_W    = 15,
  parameter int UIP_LEAD = 8,
  parameter int UPD_LEN  = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic [2:0]       dv,
  input  logic [3:0]       rate,
  input  logic             set_mode,
  input  logic             sqwe,
  output logic             tick,
  output logic             uip,
  output logic             sqw,
  output logic [PRE_W-1:0] cnt
);
  import rtc_pkg::*;

  localparam int TOP = 1 << PRE_W;
  localparam logic [PRE_W-1:0] LEAD_AT = PRE_W'(TOP - UIP_LEAD);
  localparam int WIN_W = $clog2(UPD_LEN + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(UPD_LEN);

  logic             run, clr, step, wrap, rate_on;
  logic [PRE_W-1:0] mask;
  logic [WIN_W-1:0] win;

  assign run     = (dv == DV_RUN);
  assign clr     = (dv[2:1] == 2'b11);
  assign step    = run & ref_en;
  assign rate_on = (rate != 4'd0);
  assign wrap    = step & (cnt == '1);

  generate
    for (genvar b = 0; b < PRE_W; b++) begin : g_mask
      assign mask[b] = rate_on && (b < (int'(rate) - 1));
    end
  endgenerate

  assign tick = step & rate_on & ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (clr) begin
      win <= '0;
    end else if (wrap) begin
      win <= WIN_LOAD;
    end else if (step && win != '0) begin
      win <= win - 1'b1;
    end
  end

  assign uip = run & ~set_mode & ((cnt >= LEAD_AT) | (win != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqw <= 1'b0;
    end else if (!(sqwe && rate_on)) begin
      sqw <= 1'b0;
    end else if (tick) begin
      sqw <= ~sqw;
    end
  end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_per,
  input  logic            set_alm,
  input  logic            set_upd_raw,
  input  logic            set_mode,
  input  logic            rd_clr,
  input  logic [2:0]      en,
  output rtc_pkg::flags_t flg,
  output logic            summary
);
  import rtc_pkg::*;

  flags_t sets;

  always_comb begin
    sets.per = set_per;
    sets.alm = set_alm;
    sets.upd = set_upd_raw & ~set_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= '0;
    end else if (rd_clr) begin
      flg <= sets;
    end else begin
      flg <= flg | sets;
    end
  end

  assign summary = |(flg & en);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs #(
  parameter logic [6:0] FREQ_RST = 7'h26,
  parameter logic [7:0] CTRL_RST = 8'h02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel,
  input  logic            wr,
  input  logic [7:0]      wdata,
  input  logic            uip,
  input  rtc_pkg::flags_t flg,
  input  logic            summary,
  output logic [6:0]      freq,
  output logic [7:0]      ctrl,
  output logic [7:0]      rdata
);
  import rtc_pkg::*;

  reg_idx_e idx;
  assign idx = reg_idx_e'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq <= FREQ_RST;
      ctrl <= CTRL_RST;
    end else if (wr) begin
      case (idx)
        IDX_FREQ: freq <= wdata[6:0];
        IDX_CTRL: ctrl <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_FREQ: rdata = {uip, freq};
      IDX_CTRL: rdata = ctrl;
      IDX_FLAG: rdata = {summary, flg.per, flg.alm, flg.upd, 4'b0000};
      default:  rdata = 8'h80;
    endcase
  end
endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq #(
  parameter int         PRE_W    = 15,
  parameter int         UIP_LEAD = 8,
  parameter int         UPD_LEN  = 65,
  parameter logic [6:0] FREQ_RST = 7'h26,
  parameter logic [7:0] CTRL_RST = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       alarm_hit,
  input  logic       upd_done,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sqw_out,
  output logic       set_inhibit
);
  import rtc_pkg::*;

  logic [6:0]       freq_q;
  logic [7:0]       ctrl_q;
  logic             tick, uip, summary, rd_clr;
  logic [PRE_W-1:0] cnt;
  flags_t           flg;

  assign rd_clr = reg_rd & (reg_sel == IDX_FLAG);

  rtc_divider #(
    .PRE_W(PRE_W), .UIP_LEAD(UIP_LEAD), .UPD_LEN(UPD_LEN)
  ) div_u (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
    .dv(freq_q[6:4]), .rate(freq_q[3:0]),
    .set_mode(ctrl_q[CB_SET]), .sqwe(ctrl_q[CB_SQWE]),
    .tick(tick), .uip(uip), .sqw(sqw_out), .cnt(cnt)
  );

  rtc_flags flags_u (
    .clk(clk), .rst_n(rst_n),
    .set_per(tick), .set_alm(alarm_hit), .set_upd_raw(upd_done),
    .set_mode(ctrl_q[CB_SET]), .rd_clr(rd_clr),
    .en({ctrl_q[CB_PIE], ctrl_q[CB_AIE], ctrl_q[CB_UIE]}),
    .flg(flg), .summary(summary)
  );

  rtc_regs #(
    .FREQ_RST(FREQ_RST), .CTRL_RST(CTRL_RST)
  ) regs_u (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr),
    .wdata(reg_wdata), .uip(uip), .flg(flg), .summary(summary),
    .freq(freq_q), .ctrl(ctrl_q), .rdata(reg_rdata)
  );

  assign irq         = summary;
  assign set_inhibit = ctrl_q[CB_SET];
endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk #(
  parameter int PRE_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alarm_hit,
  input logic             upd_done,
  input logic [1:0]       reg_sel,
  input logic             reg_rd,
  input logic             sqw_out,
  input logic [6:0]       freq_q,
  input logic [7:0]       ctrl_q,
  input logic             tick,
  input logic             uip,
  input logic [PRE_W-1:0] cnt,
  input rtc_pkg::flags_t  flg
);
  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_q[6:5] == 2'b11) |=> (cnt == '0)); // R2

  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_q[3:0] == 4'd0) |-> !tick); // R1

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd2 && !tick && !alarm_hit && !upd_done) |=> (flg == '0)); // R5

  AST_SQW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q[3] && freq_q[3:0] != 4'd0) |=> !sqw_out); // R7

  AST_SET_HIDES_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |-> !uip); // R8

  AST_SET_BLOCKS_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !flg.upd) |=> !flg.upd); // R9
endmodule

bind rtc_tick_irq rtc_tick_irq_chk #(.PRE_W(PRE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alarm_hit(alarm_hit), .upd_done(upd_done),
  .reg_sel(reg_sel), .reg_rd(reg_rd), .sqw_out(sqw_out),
  .freq_q(freq_q), .ctrl_q(ctrl_q), .tick(tick), .uip(uip),
  .cnt(cnt), .flg(flg)
);

// File: tb/rtc_tick_irq_tb_top.sv
module rtc_tick_irq_tb_top;
  localparam int PW   = 10;
  localparam int LEAD = 8;
  localparam int ULEN = 65;
  localparam int NCYC = 40000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0, alarm_hit = 1'b0, upd_done = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, sqw_out, set_inhibit;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_tick_irq #(.PRE_W(PW), .UIP_LEAD(LEAD), .UPD_LEN(ULEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .alarm_hit(alarm_hit),
    .upd_done(upd_done), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sqw_out(sqw_out), .set_inhibit(set_inhibit)
  );

  // reference model state
  logic [6:0]    m_freq;
  logic [7:0]    m_ctrl;
  logic [PW-1:0] m_cnt;
  int            m_win;
  logic          m_pf, m_af, m_uf, m_sqw;

  function automatic logic m_run();
    return m_freq[6:4] == 3'b010;
  endfunction

  function automatic logic m_sum();
    return (m_pf & m_ctrl[6]) | (m_af & m_ctrl[5]) | (m_uf & m_ctrl[4]);
  endfunction

  function automatic logic m_uip();
    return m_run() && !m_ctrl[7] &&
           ((int'(m_cnt) >= (1 << PW) - LEAD) || m_win != 0);
  endfunction

  function automatic logic [7:0] exp_rdata(logic [1:0] s);
    case (s)
      2'd0: return {m_uip(), m_freq};
      2'd1: return m_ctrl;
      2'd2: return {m_sum(), m_pf, m_af, m_uf, 4'b0000};
      default: return 8'h80;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_freq = 7'h26; m_ctrl = 8'h02; m_cnt = '0; m_win = 0;
      m_pf = 0; m_af = 0; m_uf = 0; m_sqw = 0;
    end else begin
      logic step, tk, rate_on, wrapv, clr, rdc, nuf;
      int per;
      rate_on = m_freq[3:0] != 0;
      step  = m_run() && ref_en;
      clr   = m_freq[6:5] == 2'b11;
      per   = rate_on ? (1 << (int'(m_freq[3:0]) - 1)) : 1;
      tk    = step && rate_on && ((int'(m_cnt) % per) == per - 1);
      wrapv = step && (m_cnt == '1);
      rdc   = reg_rd && reg_sel == 2'd2;
      nuf   = upd_done && !m_ctrl[7];
      if (rdc) begin
        m_pf = tk; m_af = alarm_hit; m_uf = nuf;
      end else begin
        m_pf = m_pf | tk; m_af = m_af | alarm_hit; m_uf = m_uf | nuf;
      end
      if (!(m_ctrl[3] && rate_on)) m_sqw = 0;
      else if (tk) m_sqw = ~m_sqw;
      if (clr) m_win = 0;
      else if (wrapv) m_win = ULEN;
      else if (step && m_win != 0) m_win = m_win - 1;
      if (clr) m_cnt = '0;
      else if (step) m_cnt = m_cnt + 1'b1;
      if (reg_wr && reg_sel == 2'd0) m_freq = reg_wdata[6:0];
      if (reg_wr && reg_sel == 2'd1) m_ctrl = reg_wdata;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    case (reg_sel)
      2'd0: t = "R8/R11/R1 freq read";
      2'd1: t = "R3 ctrl read";
      2'd2: t = "R4/R5/R9 flag read";
      default: t = "R10 validity read";
    endcase
    check(reg_rdata, exp_rdata(reg_sel), t);
    check({7'b0, irq}, {7'b0, m_sum()}, "R6 irq");
    check({7'b0, sqw_out}, {7'b0, m_sqw}, "R7 sqw_out");
    check({7'b0, set_inhibit}, {7'b0, m_ctrl[7]}, "R3 set_inhibit");
  endtask

  task automatic random_ops(input int i, input bit directed);
    logic [2:0] dvp;
    ref_en    = (i % 2) == 0;
    alarm_hit = ($urandom % 40) == 0;
    upd_done  = ($urandom % 40) == 0;
    reg_sel   = 2'($urandom);
    reg_rd    = ($urandom % 6) == 0;
    reg_wr    = 1'b0;
    reg_wdata = 8'($urandom);
    if (directed) begin
      // long run stretch, inhibit low, to cross several wraps (R8)
      if ((i % 1500) == 3) begin
        reg_wr = 1'b1; reg_sel = 2'd1;
        reg_wdata = {1'b0, 3'b111, 1'b1, 3'b010};
      end else if ((i % 1500) == 700) begin
        reg_wr = 1'b1; reg_sel = 2'd0;
        reg_wdata = {1'b1, 3'b010, 4'(1 + (i / 1500) % 6)};
      end
    end else if (($urandom % 300) == 0) begin
      reg_wr = 1'b1; reg_sel = 2'd0;
      case ($urandom % 8)
        0: dvp = 3'b110;
        1: dvp = 3'b000;
        2: dvp = 3'b111;
        default: dvp = 3'b010;
      endcase
      reg_wdata = {1'($urandom), dvp, 4'($urandom % 7)};
    end else if (($urandom % 150) == 0) begin
      reg_wr = 1'b1; reg_sel = 2'd1;
      reg_wdata[7] = ($urandom % 4) == 0;
    end else if (($urandom % 200) == 0) begin
      reg_wr = 1'b1; reg_sel = 2'(2 + $urandom % 2); // R4 R10 ignored writes
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, every register
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s);
      #1;
      check(reg_rdata, exp_rdata(2'(s)), "R11/R3/R4/R10 reset value");
    end
    check({7'b0, irq}, 8'h00, "R6 reset irq");
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      compare_all();
      random_ops(i, i < 9000);
      // directed collision: read flags while alarm pulses (R5)
      if (i == 9100) begin
        reg_sel = 2'd2; reg_rd = 1'b1; alarm_hit = 1'b1; reg_wr = 1'b0;
      end
    end
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule